// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a 64-word first-in/first-out buffer with a width of 4 or 5 bits. Data enters on a shift-in strobe and leaves on a shift-out strobe. The oldest stored word always sits on the data output, and a flag marks it as valid, so a reader never has to request a word before it can see it. A second flag tells a writer that there is room for another word. An optional output enable switches the data outputs to high impedance.

Both sides follow valid/ready rules. On the write side, `shift_in` acts as valid and `in_ready` acts as ready. A word is taken on a rising clock edge only when both are high, so a writer that is held back keeps its word and strobe until `in_ready` returns. On the read side, `out_ready` acts as valid and `shift_out` acts as ready. The word on `dout` is consumed on an edge where both are high, and it stays put while `shift_out` is low.

Units chain for extra depth. Each unit's `dout` feeds the next unit's `din`, its `out_ready` drives the next unit's `shift_in`, and the next unit's `in_ready` drives its `shift_out`. Units also sit side by side for extra width. In that case the `in_ready` flags are ANDed into one composite flag, and the `out_ready` flags are ANDed into another.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds exactly DEPTH (64) words. After reset, 64 consecutive shift-ins are all accepted. WIDTH is 4 or 5.
- R2: Words leave in the order they were written. While `out_ready` is high, `dout` shows the oldest stored word.
- R3: `in_ready` is high exactly when fewer than 64 words are stored.
- R4: `out_ready` is high exactly when at least one word is stored.
- R5: A shift-in while the buffer is full is ignored. The flags and the stored words do not change.
- R6: A shift-out while the buffer is empty is ignored. The buffer stays empty.
- R7: When shift-in and shift-out fall on the same edge and the buffer is neither full nor empty, both take effect and occupancy does not change. At full, only the shift-out takes effect. At empty, only the shift-in takes effect.
- R8: With `mreset` high at a rising edge, the buffer empties. After that edge `in_ready` is 1, `out_ready` is 0, and earlier words are discarded.
- R9: A word written into an empty buffer appears on `dout`, with `out_ready` high, right after the writing edge.
- R10: With HAS_OE=1, `dout` is high impedance while `oe` is 0 and shows the oldest word while `oe` is 1. With HAS_OE=0, `dout` is always driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| mreset | input | 1 | Master reset, synchronous, active high |
| shift_in | input | 1 | Write strobe (valid of the write side) |
| din | input | WIDTH | Word to be written |
| in_ready | output | 1 | Room for a word (ready of the write side) |
| shift_out | input | 1 | Read strobe (ready of the read side) |
| out_ready | output | 1 | `dout` holds a valid word (valid of the read side) |
| oe | input | 1 | Output enable (used when HAS_OE=1) |
| dout | output | WIDTH | Oldest stored word, or high impedance |

## Verification
The bench first fills the buffer with single writes, checking the flags at every occupancy from 0 to 64. It then drains the buffer with single reads, checking the word order. These two passes separate a pointer or counter error from an error in the flag thresholds. Strobes that coincide are tried at full, at empty and at mid occupancy, which tells the three acceptance rules apart. A long run of interleaved strobes mixes partial fills with wrap-around of both pointers. Writes at full, reads at empty, a reset in the middle of a stream and toggling of the output enable each show whether ignored or flushed state leaks out at the ports.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Operation actually performed on one edge, after the full/empty gating.
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } sf_op_e;

  function automatic sf_op_e sf_classify(input logic wr, input logic rd);
    return sf_op_e'({rd, wr});
  endfunction
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          shift_in,
  input  logic          shift_out,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          in_ready,
  output logic          out_ready
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [CW-1:0] count_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          full, empty, rd_en;
  sf_op_e        op;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count_q == FULL_CNT);
  assign empty = (count_q == '0);
  assign wr_en = shift_in & ~full;
  assign rd_en = shift_out & ~empty;
  assign op    = sf_classify(wr_en, rd_en);

  always_ff @(posedge clk) begin
    if (mreset) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          wr_ptr_q <= advance(wr_ptr_q);
          count_q  <= count_q + CW'(1);
        end
        OP_POP: begin
          rd_ptr_q <= advance(rd_ptr_q);
          count_q  <= count_q - CW'(1);
        end
        OP_SWAP: begin
          wr_ptr_q <= advance(wr_ptr_q);
          rd_ptr_q <= advance(rd_ptr_q);
        end
        default: ;
      endcase
    end
  end

  assign wr_addr   = wr_ptr_q;
  assign rd_addr   = rd_ptr_q;
  assign in_ready  = ~full;
  assign out_ready = ~empty;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Asynchronous read: the head word falls through without a read cycle.
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sfifo_drive.sv
module sfifo_drive #(
  parameter int WIDTH  = 5,
  parameter bit HAS_OE = 1'b1
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] dout
);
  generate
    if (HAS_OE) begin : g_tristate
      assign dout = oe ? word : {WIDTH{1'bz}};
    end else begin : g_always_on
      logic unused_oe;
      assign unused_oe = oe;
      assign dout = word;
    end
  endgenerate
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int WIDTH  = 5,
  parameter int DEPTH  = 64,
  parameter bit HAS_OE = 1'b1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mreset,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  input  logic             oe,
  output logic [WIDTH-1:0] dout
);
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WIDTH-1:0] head;

  sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .mreset    (mreset),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .in_ready  (in_ready),
    .out_ready (out_ready)
  );

  sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (head)
  );

  sfifo_drive #(.WIDTH(WIDTH), .HAS_OE(HAS_OE)) u_drive (
    .oe   (oe),
    .word (head),
    .dout (dout)
  );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int WIDTH = 5
) (
  input logic             clk,
  input logic             mreset,
  input logic             shift_in,
  input logic             in_ready,
  input logic             shift_out,
  input logic             out_ready,
  input logic             oe,
  input logic [WIDTH-1:0] dout
);
  // R3/R4: a full buffer is never empty
  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (mreset)
    !in_ready |-> out_ready);

  // R2: an unread head word stays on the output
  a_r2_head_hold: assert property (@(posedge clk) disable iff (mreset)
    (out_ready && !shift_out && oe) |=> (out_ready && (!oe || $stable(dout))));

  // R5: a write at full does not change the full state
  a_r5_full_ignore: assert property (@(posedge clk) disable iff (mreset)
    (!in_ready && shift_in && !shift_out) |=> !in_ready);

  // R6: a read at empty leaves the buffer empty
  a_r6_empty_ignore: assert property (@(posedge clk) disable iff (mreset)
    (!out_ready && shift_out && !shift_in) |=> !out_ready);

  // R7: coincident strobes in the middle keep both flags high
  a_r7_steady: assert property (@(posedge clk) disable iff (mreset)
    (in_ready && out_ready && shift_in && shift_out) |=> (in_ready && out_ready));

  // R8: leaving reset the buffer is empty
  a_r8_reset_empty: assert property (@(posedge clk) disable iff (mreset)
    $fell(mreset) |-> (in_ready && !out_ready));

  // R9: a write into an empty buffer is visible after one edge
  a_r9_fall_through: assert property (@(posedge clk) disable iff (mreset)
    (!out_ready && shift_in) |=> out_ready);
endmodule

bind strobe_fifo strobe_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .mreset    (mreset),
  .shift_in  (shift_in),
  .in_ready  (in_ready),
  .shift_out (shift_out),
  .out_ready (out_ready),
  .oe        (oe),
  .dout      (dout)
);

// File: tb/strobe_fifo_tb.sv
`timescale 1ns/1ps
module strobe_fifo_tb;
  localparam int W = 5;
  localparam int D = 64;

  logic clk = 1'b0;
  logic mreset = 1'b1;
  logic shift_in = 1'b0;
  logic shift_out = 1'b0;
  logic oe = 1'b1;
  logic [W-1:0] din = '0;
  wire  [W-1:0] dout;
  wire in_ready, out_ready;

  int errors = 0;
  int checks = 0;
  int wi = 0;
  int ri = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strobe_fifo #(.WIDTH(W), .DEPTH(D), .HAS_OE(1'b1)) u_dut (
    .clk(clk), .mreset(mreset), .shift_in(shift_in), .din(din),
    .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
    .oe(oe), .dout(dout)
  );

  // Word number i carries a nonzero value so it differs from an undriven bus.
  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 7 + 3) % ((1 << W) - 1) + 1);
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    int cnt = wi - ri;
    chk({tag, " in_ready (R3)"}, in_ready == (cnt < D), int'(in_ready), int'(cnt < D));
    chk({tag, " out_ready (R4)"}, out_ready == (cnt > 0), int'(out_ready), int'(cnt > 0));
    if (cnt > 0)
      chk({tag, " head word (R2)"}, dout === pat(ri), int'(dout), int'(pat(ri)));
  endtask

  task automatic step(input bit si, input bit so, input logic [W-1:0] d, input string tag);
    int cnt;
    @(negedge clk);
    shift_in = si; shift_out = so; din = d;
    @(posedge clk);
    #1;
    cnt = wi - ri;
    if (si && cnt < D) wi++;
    if (so && cnt > 0) ri++;
    shift_in = 1'b0; shift_out = 1'b0;
    verify(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    verify("R8 initial reset");
    @(negedge clk); mreset = 1'b0;

    step(1'b0, 1'b1, '0, "R6 read at empty");

    for (int i = 0; i < D; i++) step(1'b1, 1'b0, pat(wi), "R1 fill");
    chk("R1 full after 64 writes", wi == D && !in_ready, int'(in_ready), 0);

    step(1'b1, 1'b0, '1, "R5 write at full");
    step(1'b1, 1'b1, '1, "R7 both at full");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, pat(wi), "R7 both mid");
    while (wi - ri > 0) step(1'b0, 1'b1, '0, "R2 drain");

    step(1'b1, 1'b1, pat(wi), "R7 R9 both at empty");
    step(1'b0, 1'b1, '0, "R2 drain single");
    step(1'b1, 1'b0, pat(wi), "R9 fall-through");

    @(negedge clk); oe = 1'b0; #1;
    chk("R10 oe low releases dout", dout !== pat(ri), int'(dout), 0);
    @(negedge clk); oe = 1'b1; #1;
    chk("R10 oe high drives dout", dout === pat(ri), int'(dout), int'(pat(ri)));

    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, pat(wi), "R4 partial fill");
    @(negedge clk); mreset = 1'b1;
    @(posedge clk); #1;
    ri = wi;
    verify("R8 mid-stream reset");
    @(negedge clk); mreset = 1'b0;
    step(1'b1, 1'b0, pat(wi), "R8 first word after reset");

    for (int j = 0; j < 400; j++)
      step((j % 3) != 0, (j % 5) < 2, pat(wi), "R2 mixed stream");
    for (int j = 0; j < 150; j++)
      step((j % 4) != 3, (j % 7) == 0, pat(wi), "R3 mixed toward full");
    while (wi - ri > 0) step(1'b0, 1'b1, '0, "R2 final drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule